// File: doc/BRIEF.md
# Dual-Requester Transceiver Reconfiguration Arbiter

This block lets a receive-side and a transmit-side reconfiguration manager share the one memory-mapped reconfiguration port of a physical transceiver channel. That port accepts only one access stream at a time. Each manager raises its enable while it wants the channel. The block grants the channel to one side, forwards that side's command (write, read, address, write data, channel select) to the shared port, and returns read data and waitrequest only to the side that holds the grant. The side without the grant sees waitrequest held high and read data of zero.

The block also decides what calibration-busy status each side's PHY reset controller sees. The owner sees its own raw busy. The other side is held busy, so the two sides never recalibrate over each other. A grant is kept until its side has dropped its enable and its access strobes and its raw calibration has finished. The next waiting side is then granted on that same clock edge.

Top module: `xcvr_rcfg_arb`

## Requirements
- R1: While rst_ni is low, the shared port's write and read are low, both requester waitrequests are high, both gated calibration-busy outputs are high and no side is granted.
- R2: A side whose enable is sampled high while no side is granted owns the channel from the next clock edge. While it owns the channel, the shared write, read, channel, address and write data equal that side's inputs.
- R3: If both enables are sampled high while no side is granted, the first such contention after reset grants receive. Each later contention grants the side that lost the previous contention. A grant made without contention does not change this order.
- R4: An owner keeps its grant as long as any of these is high: its enable, its write or read, or its raw calibration-busy. It is released at the first edge where all of them are sampled low.
- R5: A side without the grant has its write and read ignored: the shared port carries the owner's command, or all zeros when nobody owns it. Its waitrequest is 1 and its read data is 0.
- R6: The owner's read data and waitrequest come from its own return channel. The other side's return channel has no effect on them.
- R7: The owner's gated calibration-busy equals its raw calibration-busy. The other side's gated calibration-busy is 1.
- R8: When no side owns the channel and reset is high, each gated calibration-busy is the OR of both raw calibration-busy inputs.
- R9: The two requester waitrequests are never low in the same cycle. When both raw calibration-busy inputs are high, at least one gated output is high.
- R10: When an owner is released while the other side's enable is high, the other side is granted on that same edge, with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the reconfiguration managers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive side requests the channel |
| rx_chan_i | input | CHAN_W | Receive side channel select |
| rx_write_i | input | 1 | Receive side write strobe |
| rx_read_i | input | 1 | Receive side read strobe |
| rx_addr_i | input | ADDR_W | Receive side address |
| rx_wdata_i | input | DATA_W | Receive side write data |
| rx_rdata_o | output | DATA_W | Read data returned to receive side |
| rx_wait_o | output | 1 | Waitrequest to receive side |
| tx_en_i | input | 1 | Transmit side requests the channel |
| tx_chan_i | input | CHAN_W | Transmit side channel select |
| tx_write_i | input | 1 | Transmit side write strobe |
| tx_read_i | input | 1 | Transmit side read strobe |
| tx_addr_i | input | ADDR_W | Transmit side address |
| tx_wdata_i | input | DATA_W | Transmit side write data |
| tx_rdata_o | output | DATA_W | Read data returned to transmit side |
| tx_wait_o | output | 1 | Waitrequest to transmit side |
| xc_write_o | output | 1 | Shared port write |
| xc_read_o | output | 1 | Shared port read |
| xc_chan_o | output | CHAN_W | Shared port channel select |
| xc_addr_o | output | ADDR_W | Shared port address |
| xc_wdata_o | output | DATA_W | Shared port write data |
| rx_xc_rdata_i | input | DATA_W | Read data from the receive-side return channel |
| rx_xc_wait_i | input | 1 | Waitrequest from the receive-side return channel |
| tx_xc_rdata_i | input | DATA_W | Read data from the transmit-side return channel |
| tx_xc_wait_i | input | 1 | Waitrequest from the transmit-side return channel |
| rx_cal_busy_i | input | 1 | Raw receive calibration busy |
| tx_cal_busy_i | input | 1 | Raw transmit calibration busy |
| rx_cal_busy_o | output | 1 | Gated calibration busy to the receive reset controller |
| tx_cal_busy_o | output | 1 | Gated calibration busy to the transmit reset controller |

## Verification
The release of one grant and the grant of the other can happen on the same edge. The switch of both gated calibration-busy outputs and both waitrequests happens in the cycle that follows that edge. The bench provokes this by having the owner drop its enable, strobes and raw busy while the other side keeps its enable high. It then checks that the shared port carries the new owner's address, and that the waitrequests and gated busy outputs have swapped with no idle cycle. A contention also lands on this kind of edge, and it is judged by the alternating grant order. The behavioural model is compared every cycle under random enables, strobes, raw busy inputs and reset pulses.

// File: rtl/xcvr_rcfg_arb_pkg.sv
package xcvr_rcfg_arb_pkg;
  localparam int unsigned N_SIDES = 2;
  localparam int unsigned SIDE_RX = 0;
  localparam int unsigned SIDE_TX = 1;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RX   = 2'd1,
    OWN_TX   = 2'd2
  } owner_e;
endpackage

// File: rtl/xcvr_rcfg_arb_ctrl.sv
module xcvr_rcfg_arb_ctrl
  import xcvr_rcfg_arb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SIDES-1:0] en_i,
  input  logic [N_SIDES-1:0] acc_i,
  input  logic [N_SIDES-1:0] cal_i,
  output logic [N_SIDES-1:0] gnt_o
);
  owner_e owner_q, owner_d;
  logic   pref_tx_q, pref_tx_d;
  logic   rel;

  always_comb begin
    unique case (owner_q)
      OWN_RX:  rel = ~(en_i[SIDE_RX] | acc_i[SIDE_RX] | cal_i[SIDE_RX]);
      OWN_TX:  rel = ~(en_i[SIDE_TX] | acc_i[SIDE_TX] | cal_i[SIDE_TX]);
      default: rel = 1'b1;
    endcase
  end

  // round-robin pointer only moves on contention
  always_comb begin
    owner_d   = owner_q;
    pref_tx_d = pref_tx_q;
    if (rel) begin
      if (&en_i) begin
        owner_d   = pref_tx_q ? OWN_TX : OWN_RX;
        pref_tx_d = ~pref_tx_q;
      end else if (en_i[SIDE_RX]) begin
        owner_d = OWN_RX;
      end else if (en_i[SIDE_TX]) begin
        owner_d = OWN_TX;
      end else begin
        owner_d = OWN_NONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q   <= OWN_NONE;
      pref_tx_q <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      pref_tx_q <= pref_tx_d;
    end
  end

  assign gnt_o[SIDE_RX] = (owner_q == OWN_RX);
  assign gnt_o[SIDE_TX] = (owner_q == OWN_TX);
endmodule

// File: rtl/xcvr_rcfg_arb_cmd_mux.sv
module xcvr_rcfg_arb_cmd_mux
  import xcvr_rcfg_arb_pkg::*;
#(
  parameter int unsigned CMD_W = 46
) (
  input  logic [N_SIDES-1:0]            gnt_i,
  input  logic [N_SIDES-1:0][CMD_W-1:0] cmd_i,
  output logic [CMD_W-1:0]              cmd_o
);
  // and-or select, zero when idle
  always_comb begin
    cmd_o = '0;
    for (int s = 0; s < N_SIDES; s++) begin
      if (gnt_i[s]) cmd_o = cmd_o | cmd_i[s];
    end
  end
endmodule

// File: rtl/xcvr_rcfg_arb_side_gate.sv
module xcvr_rcfg_arb_side_gate #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              rst_ni,
  input  logic              own_self_i,
  input  logic              own_other_i,
  input  logic              cal_self_i,
  input  logic              cal_other_i,
  input  logic              xc_wait_i,
  input  logic [DATA_W-1:0] xc_rdata_i,
  output logic              wait_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cal_busy_o
);
  assign wait_o  = ~own_self_i | xc_wait_i;
  assign rdata_o = own_self_i ? xc_rdata_i : '0;

  always_comb begin
    if (!rst_ni)          cal_busy_o = 1'b1;
    else if (own_self_i)  cal_busy_o = cal_self_i;
    else if (own_other_i) cal_busy_o = 1'b1;
    else                  cal_busy_o = cal_self_i | cal_other_i;
  end
endmodule

// File: rtl/xcvr_rcfg_arb.sv
module xcvr_rcfg_arb
  import xcvr_rcfg_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic [CHAN_W-1:0] rx_chan_i,
  input  logic              rx_write_i,
  input  logic              rx_read_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  output logic [DATA_W-1:0] rx_rdata_o,
  output logic              rx_wait_o,
  input  logic              tx_en_i,
  input  logic [CHAN_W-1:0] tx_chan_i,
  input  logic              tx_write_i,
  input  logic              tx_read_i,
  input  logic [ADDR_W-1:0] tx_addr_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  output logic [DATA_W-1:0] tx_rdata_o,
  output logic              tx_wait_o,
  output logic              xc_write_o,
  output logic              xc_read_o,
  output logic [CHAN_W-1:0] xc_chan_o,
  output logic [ADDR_W-1:0] xc_addr_o,
  output logic [DATA_W-1:0] xc_wdata_o,
  input  logic [DATA_W-1:0] rx_xc_rdata_i,
  input  logic              rx_xc_wait_i,
  input  logic [DATA_W-1:0] tx_xc_rdata_i,
  input  logic              tx_xc_wait_i,
  input  logic              rx_cal_busy_i,
  input  logic              tx_cal_busy_i,
  output logic              rx_cal_busy_o,
  output logic              tx_cal_busy_o
);
  localparam int unsigned CMD_W = 2 + CHAN_W + ADDR_W + DATA_W;

  logic [N_SIDES-1:0]             gnt, en, acc, cal, xc_wait, wait_s, cal_o;
  logic [N_SIDES-1:0][CMD_W-1:0]  cmd_side;
  logic [N_SIDES-1:0][DATA_W-1:0] xc_rdata, rdata_s;
  logic [CMD_W-1:0]               cmd_sel;
  logic                           gnt_rx, gnt_tx;

  assign en  = {tx_en_i, rx_en_i};
  assign acc = {tx_write_i | tx_read_i, rx_write_i | rx_read_i};
  assign cal = {tx_cal_busy_i, rx_cal_busy_i};
  assign xc_wait  = {tx_xc_wait_i, rx_xc_wait_i};
  assign xc_rdata = {tx_xc_rdata_i, rx_xc_rdata_i};
  assign cmd_side[SIDE_RX] = {rx_write_i, rx_read_i, rx_chan_i, rx_addr_i, rx_wdata_i};
  assign cmd_side[SIDE_TX] = {tx_write_i, tx_read_i, tx_chan_i, tx_addr_i, tx_wdata_i};

  xcvr_rcfg_arb_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .acc_i  (acc),
    .cal_i  (cal),
    .gnt_o  (gnt)
  );

  xcvr_rcfg_arb_cmd_mux #(.CMD_W(CMD_W)) u_mux (
    .gnt_i (gnt),
    .cmd_i (cmd_side),
    .cmd_o (cmd_sel)
  );

  assign {xc_write_o, xc_read_o, xc_chan_o, xc_addr_o, xc_wdata_o} = cmd_sel;

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    xcvr_rcfg_arb_side_gate #(.DATA_W(DATA_W)) u_gate (
      .rst_ni      (rst_ni),
      .own_self_i  (gnt[s]),
      .own_other_i (gnt[N_SIDES-1-s]),
      .cal_self_i  (cal[s]),
      .cal_other_i (cal[N_SIDES-1-s]),
      .xc_wait_i   (xc_wait[s]),
      .xc_rdata_i  (xc_rdata[s]),
      .wait_o      (wait_s[s]),
      .rdata_o     (rdata_s[s]),
      .cal_busy_o  (cal_o[s])
    );
  end

  assign rx_wait_o     = wait_s[SIDE_RX];
  assign tx_wait_o     = wait_s[SIDE_TX];
  assign rx_rdata_o    = rdata_s[SIDE_RX];
  assign tx_rdata_o    = rdata_s[SIDE_TX];
  assign rx_cal_busy_o = cal_o[SIDE_RX];
  assign tx_cal_busy_o = cal_o[SIDE_TX];
  assign gnt_rx        = gnt[SIDE_RX];
  assign gnt_tx        = gnt[SIDE_TX];
endmodule

// File: rtl/xcvr_rcfg_arb_chk.sv
module xcvr_rcfg_arb_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              tx_en_i,
  input logic              rx_write_i,
  input logic              rx_read_i,
  input logic [ADDR_W-1:0] rx_addr_i,
  input logic              tx_write_i,
  input logic              tx_read_i,
  input logic [ADDR_W-1:0] tx_addr_i,
  input logic              xc_write_o,
  input logic              xc_read_o,
  input logic [ADDR_W-1:0] xc_addr_o,
  input logic              rx_wait_o,
  input logic              tx_wait_o,
  input logic              rx_cal_busy_i,
  input logic              tx_cal_busy_i,
  input logic              rx_cal_busy_o,
  input logic              tx_cal_busy_o,
  input logic              gnt_rx,
  input logic              gnt_tx
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (!xc_write_o && !xc_read_o && rx_wait_o && tx_wait_o
                             && rx_cal_busy_o && tx_cal_busy_o && !gnt_rx && !gnt_tx);
    end
  end

  // R2
  rx_grant_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_rx) |-> $past(rx_en_i));
  // R2
  tx_grant_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_tx) |-> $past(tx_en_i));
  // R2
  rx_cmd_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_rx |-> (xc_write_o == rx_write_i && xc_read_o == rx_read_i && xc_addr_o == rx_addr_i));
  // R2
  tx_cmd_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_tx |-> (xc_write_o == tx_write_i && xc_read_o == tx_read_i && xc_addr_o == tx_addr_i));
  // R4
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_rx && rx_cal_busy_i) |=> gnt_rx);
  // R4
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_tx && tx_cal_busy_i) |=> gnt_tx);
  // R7
  rx_owner_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_rx |-> (tx_cal_busy_o && tx_wait_o));
  // R7
  tx_owner_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_tx |-> (rx_cal_busy_o && rx_wait_o));
  // R9
  wait_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rx_wait_o && !tx_wait_o));
  // R9
  cal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cal_busy_i && tx_cal_busy_i) |-> (rx_cal_busy_o || tx_cal_busy_o));
endmodule

bind xcvr_rcfg_arb xcvr_rcfg_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_en_i       (rx_en_i),
  .tx_en_i       (tx_en_i),
  .rx_write_i    (rx_write_i),
  .rx_read_i     (rx_read_i),
  .rx_addr_i     (rx_addr_i),
  .tx_write_i    (tx_write_i),
  .tx_read_i     (tx_read_i),
  .tx_addr_i     (tx_addr_i),
  .xc_write_o    (xc_write_o),
  .xc_read_o     (xc_read_o),
  .xc_addr_o     (xc_addr_o),
  .rx_wait_o     (rx_wait_o),
  .tx_wait_o     (tx_wait_o),
  .rx_cal_busy_i (rx_cal_busy_i),
  .tx_cal_busy_i (tx_cal_busy_i),
  .rx_cal_busy_o (rx_cal_busy_o),
  .tx_cal_busy_o (tx_cal_busy_o),
  .gnt_rx        (gnt_rx),
  .gnt_tx        (gnt_tx)
);

// File: tb/xcvr_rcfg_arb_bench.sv
`timescale 1ns/1ps
module xcvr_rcfg_arb_bench;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_en, rx_write, rx_read, tx_en, tx_write, tx_read;
  logic [CW-1:0] rx_chan, tx_chan;
  logic [AW-1:0] rx_addr, tx_addr;
  logic [DW-1:0] rx_wdata, tx_wdata, rx_xrd, tx_xrd;
  logic rx_xw, tx_xw, rx_cb, tx_cb;
  logic [DW-1:0] rx_rdata, tx_rdata, xc_wdata;
  logic rx_wait, tx_wait, xc_write, xc_read, rx_cbo, tx_cbo;
  logic [CW-1:0] xc_chan;
  logic [AW-1:0] xc_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int m_own = 0;
  bit m_pref_tx = 1'b0;

  always #10 clk = ~clk;

  xcvr_rcfg_arb u_xcvr_rcfg_arb (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_en_i(rx_en), .rx_chan_i(rx_chan), .rx_write_i(rx_write), .rx_read_i(rx_read),
    .rx_addr_i(rx_addr), .rx_wdata_i(rx_wdata), .rx_rdata_o(rx_rdata), .rx_wait_o(rx_wait),
    .tx_en_i(tx_en), .tx_chan_i(tx_chan), .tx_write_i(tx_write), .tx_read_i(tx_read),
    .tx_addr_i(tx_addr), .tx_wdata_i(tx_wdata), .tx_rdata_o(tx_rdata), .tx_wait_o(tx_wait),
    .xc_write_o(xc_write), .xc_read_o(xc_read), .xc_chan_o(xc_chan), .xc_addr_o(xc_addr),
    .xc_wdata_o(xc_wdata),
    .rx_xc_rdata_i(rx_xrd), .rx_xc_wait_i(rx_xw), .tx_xc_rdata_i(tx_xrd), .tx_xc_wait_i(tx_xw),
    .rx_cal_busy_i(rx_cb), .tx_cal_busy_i(tx_cb), .rx_cal_busy_o(rx_cbo), .tx_cal_busy_o(tx_cbo)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: owner 0 none, 1 rx, 2 tx
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_own = 0;
      m_pref_tx = 1'b0;
    end else begin
      bit keep;
      keep = (m_own == 1 && (rx_en || rx_write || rx_read || rx_cb)) ||
             (m_own == 2 && (tx_en || tx_write || tx_read || tx_cb));
      if (!keep) begin
        if (rx_en && tx_en) begin
          m_own = m_pref_tx ? 2 : 1;
          m_pref_tx = (m_own == 1);
        end else if (rx_en) m_own = 1;
        else if (tx_en) m_own = 2;
        else m_own = 0;
      end
    end
  end

  always @(negedge clk) begin
    logic [63:0] e_cmd, a_cmd;
    logic e_rxw, e_txw, e_rxc, e_txc;
    logic [DW-1:0] e_rxd, e_txd;
    e_cmd = '0;
    if (m_own == 1) e_cmd = {rx_write, rx_read, rx_chan, rx_addr, rx_wdata};
    if (m_own == 2) e_cmd = {tx_write, tx_read, tx_chan, tx_addr, tx_wdata};
    a_cmd = {xc_write, xc_read, xc_chan, xc_addr, xc_wdata};
    e_rxw = (m_own == 1) ? rx_xw : 1'b1;
    e_txw = (m_own == 2) ? tx_xw : 1'b1;
    e_rxd = (m_own == 1) ? rx_xrd : '0;
    e_txd = (m_own == 2) ? tx_xrd : '0;
    if (!rst_ni) begin e_rxc = 1'b1; e_txc = 1'b1; end
    else if (m_own == 1) begin e_rxc = rx_cb; e_txc = 1'b1; end
    else if (m_own == 2) begin e_rxc = 1'b1; e_txc = tx_cb; end
    else begin e_rxc = rx_cb | tx_cb; e_txc = rx_cb | tx_cb; end
    if (!rst_ni) begin
      chk(a_cmd == 64'd0 && rx_wait && tx_wait && rx_cbo && tx_cbo, "R1", "reset outputs",
          {a_cmd[61:0], rx_cbo, tx_cbo}, 64'd3);
    end else begin
      chk(a_cmd == e_cmd, m_own == 0 ? "R5" : "R2", "shared command", a_cmd, e_cmd);
      chk(rx_wait == e_rxw && rx_rdata == e_rxd, m_own == 1 ? "R6" : "R5", "rx response",
          {rx_wait, rx_rdata}, {e_rxw, e_rxd});
      chk(tx_wait == e_txw && tx_rdata == e_txd, m_own == 2 ? "R6" : "R5", "tx response",
          {tx_wait, tx_rdata}, {e_txw, e_txd});
      chk(rx_cbo == e_rxc && tx_cbo == e_txc, m_own == 0 ? "R8" : "R7", "gated cal busy",
          {rx_cbo, tx_cbo}, {e_rxc, e_txc});
    end
  end

  task automatic cyc;
    @(posedge clk);
    #5;
  endtask

  task automatic idle_all;
    rx_en = 0; rx_write = 0; rx_read = 0; tx_en = 0; tx_write = 0; tx_read = 0;
    rx_cb = 0; tx_cb = 0;
  endtask

  initial begin
    rx_chan = 2'd1; tx_chan = 2'd2; rx_addr = 10'h155; tx_addr = 10'h2aa;
    rx_wdata = 32'hdead0001; tx_wdata = 32'hbeef0002;
    rx_xrd = 32'ha5a5a5a5; tx_xrd = 32'h12345678; rx_xw = 0; tx_xw = 0;
    idle_all();
    rx_en = 1; rx_write = 1; tx_en = 1; tx_write = 1;
    repeat (3) cyc();
    // R1 commands during reset do not reach the port
    chk(xc_write == 0 && rx_wait && tx_wait && rx_cbo && tx_cbo, "R1", "held in reset",
        {xc_write, rx_wait, tx_wait, rx_cbo, tx_cbo}, 5'b01111);
    rst_ni = 1;
    cyc();
    // R3 first contention goes to receive; R2 its command drives the port
    chk(rx_wait == 0 && tx_wait == 1, "R3", "first contention owner", {rx_wait, tx_wait}, 2'b01);
    chk(xc_addr == rx_addr && xc_chan == rx_chan && xc_wdata == rx_wdata, "R2", "rx command routed",
        xc_addr, rx_addr);
    // R5 loser's strobe ignored
    chk(tx_rdata == 0 && xc_addr != tx_addr, "R5", "tx ignored", tx_rdata, 0);
    rx_xw = 1; #1;
    // R6 response steering
    chk(rx_wait == 1 && rx_rdata == 32'ha5a5a5a5 && tx_rdata == 0, "R6", "rx response",
        rx_rdata, 32'ha5a5a5a5);
    rx_xw = 0; tx_xw = 1; #1;
    chk(rx_wait == 0, "R6", "tx return ignored", rx_wait, 0);
    tx_xw = 0;
    rx_en = 0; rx_write = 0; rx_cb = 1;
    cyc();
    // R4 held by raw calibration busy; R7 masking
    chk(rx_wait == 0 && tx_wait == 1, "R4", "held by cal busy", {rx_wait, tx_wait}, 2'b01);
    chk(rx_cbo == 1 && tx_cbo == 1, "R7", "owner raw, other forced", {rx_cbo, tx_cbo}, 2'b11);
    rx_cb = 0; #1;
    chk(rx_cbo == 0 && tx_cbo == 1, "R7", "owner sees raw low", {rx_cbo, tx_cbo}, 2'b01);
    cyc();
    // R10 same-edge handover to waiting tx
    chk(tx_wait == 0 && rx_wait == 1 && xc_addr == tx_addr, "R10", "handover", {rx_wait, tx_wait}, 2'b10);
    chk(tx_cbo == 0 && rx_cbo == 1, "R7", "gating follows owner", {rx_cbo, tx_cbo}, 2'b10);
    tx_en = 0; tx_write = 0;
    cyc();
    rx_cb = 1; #1;
    // R8 idle gating
    chk(rx_cbo == 1 && tx_cbo == 1, "R8", "idle or of raw", {rx_cbo, tx_cbo}, 2'b11);
    rx_cb = 0; #1;
    chk(rx_cbo == 0 && tx_cbo == 0, "R8", "idle all clear", {rx_cbo, tx_cbo}, 2'b00);
    rx_write = 1;
    cyc();
    // R5 access without enable ignored
    chk(xc_write == 0 && rx_wait == 1, "R5", "no enable no access", {xc_write, rx_wait}, 2'b01);
    rx_write = 0; rx_en = 1; tx_en = 1;
    cyc();
    chk(tx_wait == 0 && rx_wait == 1, "R3", "second contention to tx", {rx_wait, tx_wait}, 2'b10);
    rx_en = 0; tx_en = 0;
    cyc();
    rx_en = 1; tx_en = 1;
    cyc();
    chk(rx_wait == 0 && tx_wait == 1, "R3", "third contention to rx", {rx_wait, tx_wait}, 2'b01);
    rx_cb = 1; tx_cb = 1; #1;
    // R9 never both released
    chk(rx_cbo == 1 && tx_cbo == 1, "R9", "both raw busy", {rx_cbo, tx_cbo}, 2'b11);
    idle_all();
    cyc();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      cyc();
      rst_ni   = ($urandom_range(0, 299) != 0);
      rx_en    = ($urandom_range(0, 3) != 0) ? rx_en : ~rx_en;
      tx_en    = ($urandom_range(0, 3) != 0) ? tx_en : ~tx_en;
      rx_write = ($urandom_range(0, 4) == 0);
      rx_read  = ($urandom_range(0, 5) == 0);
      tx_write = ($urandom_range(0, 4) == 0);
      tx_read  = ($urandom_range(0, 5) == 0);
      rx_cb    = ($urandom_range(0, 4) == 0);
      tx_cb    = ($urandom_range(0, 4) == 0);
      rx_xw    = $urandom_range(0, 1);
      tx_xw    = $urandom_range(0, 1);
      rx_addr  = AW'($urandom);
      tx_addr  = AW'($urandom);
      rx_wdata = $urandom;
      tx_wdata = $urandom;
      rx_xrd   = $urandom;
      tx_xrd   = $urandom;
      rx_chan  = CW'($urandom);
      tx_chan  = CW'($urandom);
    end
    rst_ni = 1;
    repeat (2) cyc();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule